// File: doc/BRIEF.md
# Circular Noise Sample Update Unit

This block supplies every symbol node of a fully parallel noisy bit-flip decoder with its own random perturbation value, without generating random numbers on chip. In a preload phase it takes one externally produced unit-variance sample per clock. Each sample is scaled by a standard-deviation input and offset by the inversion threshold. The result is cut down to a narrower width and pushed into the head of a long chain of registers.

Once decoding starts, the chain stops accepting new samples and rotates by one position every clock. The last entry wraps around to the head. The first `TAPS` entries of the chain drive the symbol nodes in parallel. The chain is longer than the number of taps, so every node sees a fresh value each cycle, and the whole sequence repeats with a period equal to the chain length.

Top module: `noise_rotator`

## Requirements
- R1: While `rst` is high at a rising clock edge, every chain entry is cleared, so all taps read 0 after that edge.
- R2: With `rotate` low, each edge writes the processed sample into entry 0 and moves entry i to entry i+1. The value held in the last entry is discarded.
- R3: Samples, `sigma_i` and `thresh_i` are 7-bit sign-magnitude numbers: bit 6 is the sign (1 = negative), and bits 5:0 are the magnitude with 4 fraction bits. The scaled magnitude is floor(|sample|·|sigma|/16), saturated at 63. Its sign is the XOR of the two input signs.
- R4: The scaled value is added to `thresh_i` in sign-magnitude arithmetic. The result magnitude saturates at 63. A zero result always carries a positive sign, and so does a zero product.
- R5: The stored 6-bit value is the sum's sign in bit 5, followed by the low five magnitude bits (bits 4:0). Magnitude bit 5 is dropped.
- R6: With `rotate` high, each edge moves the last entry into entry 0 and entry i into entry i+1. After `CHAIN_LEN` such edges the chain is back to its starting contents.
- R7: With `rotate` high, `sample_i`, `sigma_i` and `thresh_i` have no effect on the chain.
- R8: Tap k of `taps_o` (bits 6k+5:6k) shows chain entry k, for k below `TAPS`. Entries at or beyond `TAPS` are not visible, but they rotate back into view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear |
| rotate | input | 1 | 0 = preload samples, 1 = circular rotation |
| sample_i | input | 7 | Unit-variance sample, sign-magnitude |
| sigma_i | input | 7 | Standard-deviation scale, sign-magnitude |
| thresh_i | input | 7 | Inversion threshold, sign-magnitude |
| taps_o | output | 6·TAPS | Per-node noise values, tap k at bits 6k+5:6k |

## Verification
The bench builds the block with an 8-entry chain and 5 taps. With these values, ten preload samples overflow the chain, so the oldest values can be seen being discarded. A full rotation period also fits in eight cycles. The three hidden entries reappear at the taps within a few cycles, which makes the wrap-around order against a reference queue directly observable. The arithmetic vectors cover saturation of the product and of the sum, dropped bits of the product and of the stored value, negative zero, and cancellation to zero.

// File: rtl/noise_rotator.sv
module noise_rotator #(
  parameter int CHAIN_LEN = 2648,
  parameter int TAPS      = 2048,
  parameter int SW        = 7,
  parameter int FRAC      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rotate,
  input  logic [SW-1:0]           sample_i,
  input  logic [SW-1:0]           sigma_i,
  input  logic [SW-1:0]           thresh_i,
  output logic [TAPS*(SW-1)-1:0]  taps_o
);
  localparam int MAG   = SW - 1;
  localparam int OW    = SW - 1;
  localparam int PW    = 2 * MAG;
  localparam logic [MAG-1:0] MAG_MAX = '1;

  logic [PW-1:0]  prod_full, prod_shr;
  logic [MAG-1:0] prod_mag;
  logic           prod_sgn;

  assign prod_full = sample_i[MAG-1:0] * sigma_i[MAG-1:0];
  assign prod_shr  = prod_full >> FRAC;
  assign prod_mag  = (|prod_shr[PW-1:MAG]) ? MAG_MAX : prod_shr[MAG-1:0];
  assign prod_sgn  = (sample_i[SW-1] ^ sigma_i[SW-1]) & (|prod_mag);

  logic [MAG-1:0] th_mag;
  logic           th_sgn;
  logic [MAG:0]   raw_mag;
  logic           raw_sgn;
  logic [MAG-1:0] sum_mag;
  logic           sum_sgn;

  assign th_mag = thresh_i[MAG-1:0];
  assign th_sgn = thresh_i[SW-1];

  always_comb begin
    if (prod_sgn == th_sgn) begin
      raw_mag = {1'b0, prod_mag} + {1'b0, th_mag};
      raw_sgn = prod_sgn;
    end else if (prod_mag >= th_mag) begin
      raw_mag = {1'b0, prod_mag} - {1'b0, th_mag};
      raw_sgn = prod_sgn;
    end else begin
      raw_mag = {1'b0, th_mag} - {1'b0, prod_mag};
      raw_sgn = th_sgn;
    end
  end

  assign sum_mag = raw_mag[MAG] ? MAG_MAX : raw_mag[MAG-1:0];
  assign sum_sgn = raw_sgn & (|sum_mag);

  logic [OW-1:0] fresh;
  assign fresh = {sum_sgn, sum_mag[MAG-2:0]};

  logic [OW-1:0] chain [CHAIN_LEN];

  always_ff @(posedge clk) begin
    if (rst)         chain[0] <= '0;
    else if (rotate) chain[0] <= chain[CHAIN_LEN-1];
    else             chain[0] <= fresh;
  end

  for (genvar i = 1; i < CHAIN_LEN; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '0;
      else     chain[i] <= chain[i-1];
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign taps_o[k*OW +: OW] = chain[k];
  end
endmodule

// File: rtl/noise_rotator_sva.sv
module noise_rotator_sva #(
  parameter int TAPS = 2048,
  parameter int SW   = 7
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   rotate,
  input logic [SW-1:0]          sample_i,
  input logic [SW-1:0]          thresh_i,
  input logic [TAPS*(SW-1)-1:0] taps_o
);
  localparam int OW  = SW - 1;
  localparam int MAG = SW - 1;

  assert_clear_R1: assert property (@(posedge clk)
    rst |=> taps_o == '0);

  assert_load_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && !rotate) |=> taps_o[TAPS*OW-1:OW] == $past(taps_o[(TAPS-1)*OW-1:0]));

  assert_rot_shift_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && rotate) |=> taps_o[TAPS*OW-1:OW] == $past(taps_o[(TAPS-1)*OW-1:0]));

  assert_zero_sample_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && !rotate && sample_i[MAG-1:0] == '0) |=>
      taps_o[OW-1:0] == {$past(thresh_i[SW-1]) & (|$past(thresh_i[MAG-1:0])),
                         $past(thresh_i[MAG-2:0])});
endmodule

bind noise_rotator noise_rotator_sva #(.TAPS(TAPS), .SW(SW)) u_sva (
  .clk(clk), .rst(rst), .rotate(rotate), .sample_i(sample_i),
  .thresh_i(thresh_i), .taps_o(taps_o)
);

// File: tb/noise_rotator_bench.sv
module noise_rotator_bench;
  localparam int LEN  = 8;
  localparam int TAPS = 5;
  localparam int NV   = 10;

  logic clk = 0, rst = 1, rotate = 0;
  logic [6:0] sample_i = '0, sigma_i = '0, thresh_i = '0;
  logic [TAPS*6-1:0] taps_o;

  int checks = 0, errors = 0;
  logic [5:0] ref_q [LEN];
  logic [5:0] snap [LEN];

  // {sample, sigma, thresh, expected stored}
  localparam logic [26:0] VEC [NV] = '{
    {7'h10, 7'h08, 7'h48, 6'h00},
    {7'h50, 7'h10, 7'h48, 6'h38},
    {7'h3F, 7'h10, 7'h10, 6'h1F},
    {7'h30, 7'h30, 7'h7F, 6'h00},
    {7'h4C, 7'h08, 7'h44, 6'h2A},
    {7'h01, 7'h0F, 7'h40, 6'h00},
    {7'h41, 7'h20, 7'h08, 6'h06},
    {7'h28, 7'h48, 7'h04, 6'h30},
    {7'h20, 7'h10, 7'h08, 6'h08},
    {7'h58, 7'h50, 7'h50, 6'h08}
  };

  noise_rotator #(.CHAIN_LEN(LEN), .TAPS(TAPS)) u_noise_rotator (
    .clk(clk), .rst(rst), .rotate(rotate), .sample_i(sample_i),
    .sigma_i(sigma_i), .thresh_i(thresh_i), .taps_o(taps_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_taps(input string req);
    for (int k = 0; k < TAPS; k++) chk(req, taps_o[k*6 +: 6], ref_q[k]);
  endtask

  task automatic shift_ref(input logic [5:0] head);
    for (int i = LEN-1; i > 0; i--) ref_q[i] = ref_q[i-1];
    ref_q[0] = head;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < LEN; i++) ref_q[i] = '0;
    @(negedge clk); @(negedge clk);
    chk_taps("R1 reset state");
    rst = 0;

    // R2 R3 R4 R5 R8: vector walk, chain overflows after LEN loads
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {sample_i, sigma_i, thresh_i} = VEC[v][26:6];
      @(posedge clk); #1;
      shift_ref(VEC[v][5:0]);
      chk("R3 R4 R5 stored value", taps_o[5:0], VEC[v][5:0]);
      chk_taps("R2 load shift");
    end

    // R6 R7 R8: rotate with busy inputs; hidden entries return
    for (int i = 0; i < LEN; i++) snap[i] = ref_q[i];
    for (int c = 0; c < LEN; c++) begin
      @(negedge clk);
      rotate = 1;
      sample_i = 7'(c * 13 + 5); sigma_i = 7'h3F; thresh_i = 7'(c * 7);
      @(posedge clk); #1;
      shift_ref(ref_q[LEN-1]);
      chk_taps("R6 R7 R8 rotation");
    end
    for (int k = 0; k < TAPS; k++) chk("R6 full period", taps_o[k*6 +: 6], snap[k]);

    // R1: reset during rotation
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    for (int i = 0; i < LEN; i++) ref_q[i] = '0;
    chk_taps("R1 clear while rotating");

    // R4 negative zero threshold with zero product, R2 fresh load after reset
    @(negedge clk); rst = 0; rotate = 0;
    sample_i = 7'h40; sigma_i = 7'h10; thresh_i = 7'h60;
    @(posedge clk); #1;
    shift_ref(6'h20);
    chk_taps("R4 R5 zero product, dropped bit");

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule